// File: doc/BRIEF.md
# Quadrature Decoder Position Counter

This block turns a pair of already-conditioned quadrature phase signals into a signed position count. It compares each sample of the two phases with the sample before it. When the step between the two samples is legal, it produces a count event and a direction. That event moves a 32-bit up/down counter by one.

A 2-bit mode selects between two decode rates. The four-edge rate counts every edge of either phase. The two-edge rate counts only the edges of phase A. The mode also selects the wrap range: either the full 32-bit range, or a range that ends at a programmable maximum and wraps symmetrically in both directions.

The counter can be written directly. It can also be cleared by an index pulse when index reload is enabled. The block also emits two one-cycle event pulses: one when the counter wraps, one when the counting direction reverses. All outputs are registered. A phase change sampled at a rising clock edge is visible on the outputs right after that same edge.

Top module: `quad_pos_counter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block sets `count` to 0, `dir_up` to 1 and both event pulses to 0, and it takes the previous phase sample as A=0, B=0.
- R2: Mode 2'b00 (four-edge, free) and mode 2'b10 (four-edge, bounded) treat every single-phase change as one count event. The phase pair {A,B} cycling 00→10→11→01→00 counts up (+1 per step) and the reverse order counts down (−1 per step).
- R3: Mode 2'b01 (two-edge, free) and mode 2'b11 (two-edge, bounded) count only changes of A while B holds. A rising with B low, or A falling with B high, counts up; the other two cases count down. A change of B alone has no effect on `count` or `dir_up`.
- R4: In the free modes (2'b00, 2'b01), an up step from 0xFFFF_FFFF gives 0 and a down step from 0 gives 0xFFFF_FFFF. Each such wrap raises `wrap_pulse` for exactly one cycle.
- R5: In the bounded modes (2'b10, 2'b11), an up step from a count at or above `max_count` gives 0 and a down step from 0 gives `max_count`. Each such wrap raises `wrap_pulse` for one cycle. A count at or below `max_count` stays at or below it.
- R6: `dir_up` holds the direction of the most recent counted step. `dir_chg_pulse` is high for one cycle after each step whose direction differs from the previous `dir_up`.
- R7: A sample in which A and B both changed is illegal: it produces no count and no change of direction.
- R8: While `enable` is 0, phase changes move neither `count` nor `dir_up`, and index pulses are ignored. The phase history is still tracked, so the first step after enabling is judged against the latest sample.
- R9: A high `wr_en` loads `wr_data` into `count` at the next edge, whatever the value of `enable`. It takes priority over an index reload and over a count event in the same cycle, and it raises no wrap pulse.
- R10: With `enable` and `idx_reload_en` both high, an `idx_pulse` clears `count` to 0 in place of any count event in that cycle. With `idx_reload_en` low, the index pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Decoder enable |
| mode | input | 2 | Decode rate and wrap range select |
| phase_a | input | 1 | Conditioned phase A |
| phase_b | input | 1 | Conditioned phase B |
| idx_pulse | input | 1 | One-cycle index event |
| idx_reload_en | input | 1 | Allows the index event to clear the counter |
| max_count | input | 32 | Upper end of the range in bounded modes |
| wr_en | input | 1 | Counter write strobe |
| wr_data | input | 32 | Counter write value |
| count | output | 32 | Position count |
| dir_up | output | 1 | Direction of the last counted step (1 = up) |
| wrap_pulse | output | 1 | One-cycle wrap event |
| dir_chg_pulse | output | 1 | One-cycle direction-reversal event |

## Verification
The assertions check several properties on every cycle:
- a write lands on the next edge;
- a disabled block holds still;
- an illegal double change moves nothing;
- a wrap always lands on 0 or on the range limit;
- the bounded count never leaves its range;
- every direction pulse matches a real flip of `dir_up`.

Some behaviour can only be shown by the bench's scenarios, where the expected values come from a behavioural reference model. This covers the correct sign of each step, in both decode rates and in both directions of rotation. It also covers the exact wrap values at 0xFFFF_FFFF and at a programmed maximum. Finally, it covers the priority order when a write, an index reload and a step fall in the same cycle.

// File: rtl/qpc_pkg.sv
// Shared mode encoding and decode helpers for the quadrature position counter.
package qpc_pkg;

    typedef enum logic [1:0] {
        QPC_X4_FREE  = 2'b00,
        QPC_X2_FREE  = 2'b01,
        QPC_X4_BOUND = 2'b10,
        QPC_X2_BOUND = 2'b11
    } qpc_mode_e;

    // True when only phase A edges are counted.
    function automatic logic mode_is_x2(input logic [1:0] m);
        return m[0];
    endfunction

    // True when wrapping uses the programmed maximum.
    function automatic logic mode_is_bounded(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/qpc_edge_decode.sv
// Phase edge decoder.
// Keeps the previous {A,B} sample and classifies the change to the current one.
// A legal single-phase change yields step=1. Its sign comes from the phase relation.
// Assumes the phases are synchronous to clk and already free of glitches.
module qpc_edge_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic x2_mode,
    input  logic phase_a,
    input  logic phase_b,
    output logic step,
    output logic step_up
);

    logic prev_a;
    logic prev_b;
    logic a_chg;
    logic b_chg;

    // Remember the last phase sample, cleared to 00 by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_a <= 1'b0;
            prev_b <= 1'b0;
        end else begin
            prev_a <= phase_a;
            prev_b <= phase_b;
        end
    end

    // Classify the transition; a double change is never a step.
    always_comb begin
        a_chg   = phase_a ^ prev_a;
        b_chg   = phase_b ^ prev_b;
        step    = x2_mode ? (a_chg & ~b_chg) : (a_chg ^ b_chg);
        step_up = phase_a ^ prev_b;
    end

endmodule

// File: rtl/qpc_dir_track.sv
// Direction tracker.
// Holds the direction of the last counted step and pulses when it reverses.
// Assumes step is already qualified by the enable.
module qpc_dir_track (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic step_up,
    output logic dir_up,
    output logic dir_chg
);

    // Latch a new direction on each counted step and flag a reversal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_up  <= 1'b1;
            dir_chg <= 1'b0;
        end else begin
            dir_chg <= step && (step_up != dir_up);
            if (step) dir_up <= step_up;
        end
    end

    // A reversal pulse always comes with a flipped direction bit.
    assert_dir_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dir_chg |-> (dir_up != $past(dir_up)));

endmodule

// File: rtl/qpc_wrap_counter.sv
// Wrapping up/down position counter.
// Priority: write, then reload to zero, then a qualified step.
// The range ends at all-ones in free mode and at max_count in bounded mode.
// Assumes step is already qualified by the enable.
module qpc_wrap_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bounded,
    input  logic [CNT_W-1:0] max_count,
    input  logic             step,
    input  logic             step_up,
    input  logic             reload,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ZERO     = '0;

    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_nxt;
    logic             wrap_nxt;

    // Select the wrap limit and form the next count.
    always_comb begin
        limit    = bounded ? max_count : ALL_ONES;
        cnt_nxt  = count;
        wrap_nxt = 1'b0;
        if (wr_en) begin
            cnt_nxt = wr_data;
        end else if (reload) begin
            cnt_nxt = ZERO;
        end else if (step) begin
            if (step_up) begin
                if (count >= limit) begin
                    cnt_nxt  = ZERO;
                    wrap_nxt = 1'b1;
                end else begin
                    cnt_nxt = count + 1'b1;
                end
            end else begin
                if (count == ZERO) begin
                    cnt_nxt  = limit;
                    wrap_nxt = 1'b1;
                end else begin
                    cnt_nxt = count - 1'b1;
                end
            end
        end
    end

    // Register the count and the wrap event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= ZERO;
            wrap  <= 1'b0;
        end else begin
            count <= cnt_nxt;
            wrap  <= wrap_nxt;
        end
    end

    // A write lands on the next edge.
    assert_write_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (count == $past(wr_data)));

    // A reload without a write clears the counter.
    assert_reload_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !wr_en) |=> (count == ZERO));

    // A wrap lands on zero or on the range limit of that edge.
    assert_wrap_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> ((count == ZERO) || (count == $past(limit))));

    // In bounded mode an in-range count stays in range.
    assert_stay_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bounded && !wr_en && (count <= max_count)) |=> (count <= $past(max_count)));

endmodule

// File: rtl/quad_pos_counter.sv
// Quadrature decoder position counter, top level.
// Decodes conditioned phases A/B into steps, tracks direction and drives
// the wrapping counter. All outputs are registered.
// Assumes phases and idx_pulse are synchronous and filtered upstream.
module quad_pos_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       mode,
    input  logic             phase_a,
    input  logic             phase_b,
    input  logic             idx_pulse,
    input  logic             idx_reload_en,
    input  logic [CNT_W-1:0] max_count,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic             dir_up,
    output logic             wrap_pulse,
    output logic             dir_chg_pulse
);

    import qpc_pkg::*;

    logic raw_step;
    logic step_up;
    logic q_step;
    logic q_reload;

    qpc_edge_decode i_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .x2_mode (mode_is_x2(mode)),
        .phase_a (phase_a),
        .phase_b (phase_b),
        .step    (raw_step),
        .step_up (step_up)
    );

    // Qualify decoded steps and index reloads with the enable.
    always_comb begin
        q_step   = enable & raw_step;
        q_reload = enable & idx_reload_en & idx_pulse;
    end

    qpc_dir_track i_dir (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (q_step),
        .step_up (step_up),
        .dir_up  (dir_up),
        .dir_chg (dir_chg_pulse)
    );

    qpc_wrap_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .bounded   (mode_is_bounded(mode)),
        .max_count (max_count),
        .step      (q_step),
        .step_up   (step_up),
        .reload    (q_reload),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .count     (count),
        .wrap      (wrap_pulse)
    );

    // A disabled block without a write holds count and direction.
    assert_disabled_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !wr_en) |=> ($stable(count) && $stable(dir_up)));

    // Both phases changing at once moves nothing.
    assert_illegal_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !wr_en && !q_reload &&
         (phase_a != $past(phase_a)) && (phase_b != $past(phase_b)))
        |=> ($stable(count) && $stable(dir_up)));

endmodule

// File: tb/test_quad_pos_counter.sv
// Self-checking bench with a behavioural reference model compared every cycle.
module test_quad_pos_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        phase_a = 1'b0;
    logic        phase_b = 1'b0;
    logic        idx_pulse = 1'b0;
    logic        idx_reload_en = 1'b0;
    logic [31:0] max_count = 32'd0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] count;
    logic        dir_up;
    logic        wrap_pulse;
    logic        dir_chg_pulse;

    int checks = 0;
    int fails  = 0;
    int pos    = 0;
    bit done   = 0;

    // reference model state
    logic [31:0] m_cnt = 32'd0;
    logic        m_dir = 1'b1;
    logic        m_wrap = 1'b0;
    logic        m_chg = 1'b0;
    logic        m_pa = 1'b0;
    logic        m_pb = 1'b0;

    always #2.5 clk = ~clk;

    quad_pos_counter i_quad_pos_counter (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
        .phase_a(phase_a), .phase_b(phase_b), .idx_pulse(idx_pulse),
        .idx_reload_en(idx_reload_en), .max_count(max_count),
        .wr_en(wr_en), .wr_data(wr_data), .count(count), .dir_up(dir_up),
        .wrap_pulse(wrap_pulse), .dir_chg_pulse(dir_chg_pulse)
    );

    function automatic int gpos(input logic a, input logic b);
        case ({a, b})
            2'b00:   return 0;
            2'b10:   return 1;
            2'b11:   return 2;
            default: return 3;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Advance the model by one edge using the inputs now applied.
    task automatic model_edge();
        int  d;
        bit  valid;
        bit  up;
        bit  bnd;
        logic [31:0] lim;
        d     = (gpos(phase_a, phase_b) - gpos(m_pa, m_pb) + 4) % 4;
        valid = (d == 1) || (d == 3);
        if (mode[0]) valid = valid && (phase_a != m_pa) && (phase_b == m_pb);
        up    = (d == 1);
        bnd   = mode[1];
        lim   = bnd ? max_count : 32'hFFFF_FFFF;
        m_wrap = 1'b0;
        m_chg  = 1'b0;
        if (enable && valid) begin
            m_chg = (up != m_dir);
            m_dir = up;
        end
        if (wr_en) m_cnt = wr_data;
        else if (enable && idx_reload_en && idx_pulse) m_cnt = 0;
        else if (enable && valid) begin
            if (up) begin
                if (m_cnt >= lim) begin m_cnt = 0; m_wrap = 1'b1; end
                else m_cnt = m_cnt + 1;
            end else begin
                if (m_cnt == 0) begin m_cnt = lim; m_wrap = 1'b1; end
                else m_cnt = m_cnt - 1;
            end
        end
        m_pa = phase_a;
        m_pb = phase_b;
    endtask

    // One cycle: inputs are set before calling, at a falling edge.
    task automatic tick(input string tag);
        model_edge();
        @(posedge clk);
        @(negedge clk);
        check(tag, "count", count, m_cnt);
        check(tag, "dir_up", {31'd0, dir_up}, {31'd0, m_dir});
        check(tag, "wrap_pulse", {31'd0, wrap_pulse}, {31'd0, m_wrap});
        check(tag, "dir_chg_pulse", {31'd0, dir_chg_pulse}, {31'd0, m_chg});
        wr_en = 1'b0;
        idx_pulse = 1'b0;
    endtask

    // Move the phase position by d quarter-cycles (d may be 2 for illegal).
    task automatic move(input int d, input string tag);
        pos = (pos + d + 4) % 4;
        case (pos)
            0: begin phase_a = 1'b0; phase_b = 1'b0; end
            1: begin phase_a = 1'b1; phase_b = 1'b0; end
            2: begin phase_a = 1'b1; phase_b = 1'b1; end
            default: begin phase_a = 1'b0; phase_b = 1'b1; end
        endcase
        tick(tag);
    endtask

    task automatic write(input logic [31:0] v, input string tag);
        wr_en = 1'b1;
        wr_data = v;
        tick(tag);
    endtask

    // watchdog
    initial begin
        #(5ns * 20000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "count", count, 32'd0);
        check("R1", "dir_up", {31'd0, dir_up}, 32'd1);
        check("R1", "wrap_pulse", {31'd0, wrap_pulse}, 32'd0);
        check("R1", "dir_chg_pulse", {31'd0, dir_chg_pulse}, 32'd0);
        rst_n = 1'b1;
        enable = 1'b1;
        mode = 2'b00;
        tick("R1");
        // R2: four-edge up then down
        for (int i = 0; i < 6; i++) move(1, "R2");
        // R6: reversal
        for (int i = 0; i < 3; i++) move(-1, "R6");
        // R4: down through zero wraps to all ones, then back up
        for (int i = 0; i < 4; i++) move(-1, "R4");
        move(1, "R4");
        write(32'hFFFF_FFFE, "R9");
        move(1, "R4");
        move(1, "R4");
        // R7: illegal double change
        move(2, "R7");
        move(1, "R7");
        // R8: disabled
        enable = 1'b0;
        move(1, "R8");
        move(1, "R8");
        idx_reload_en = 1'b1; idx_pulse = 1'b1; tick("R8");
        idx_reload_en = 1'b0;
        enable = 1'b1;
        move(-1, "R8");
        // R3: two-edge mode over full rotations both ways
        mode = 2'b01;
        write(32'd100, "R9");
        for (int i = 0; i < 8; i++) move(1, "R3");
        for (int i = 0; i < 8; i++) move(-1, "R3");
        // R5: bounded four-edge
        mode = 2'b10;
        max_count = 32'd5;
        write(32'd4, "R5");
        for (int i = 0; i < 3; i++) move(1, "R5");
        for (int i = 0; i < 3; i++) move(-1, "R5");
        write(32'd9, "R5");
        move(1, "R5");
        // R5: bounded two-edge
        mode = 2'b11;
        write(32'd0, "R5");
        for (int i = 0; i < 6; i++) move(-1, "R5");
        // R9: write beats step and reload, also while disabled
        mode = 2'b00;
        wr_en = 1'b1; wr_data = 32'h1234_5678; idx_reload_en = 1'b1; idx_pulse = 1'b1;
        move(1, "R9");
        enable = 1'b0;
        write(32'hCAFE_0001, "R9");
        enable = 1'b1;
        // R10: reload beats a step; ignored when not enabled for reload
        idx_pulse = 1'b1;
        move(1, "R10");
        move(1, "R10");
        idx_reload_en = 1'b0;
        idx_pulse = 1'b1;
        move(1, "R10");
        tick("R10");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule